// File: doc/BRIEF.md
# Chained-Descriptor 2D Copy Engine

This block is one DMA channel that copies memory word by word under the control of a linked list of descriptors held in memory. Software, through a register block, gives the engine the address of the first descriptor and pulses start. The engine reads that six-word descriptor over its memory master port. It then performs the copy the descriptor asks for, marks completion and, if the descriptor requests it, raises an interrupt. After that it moves on to the descriptor named by the link word. The walk ends when the link is zero or when the channel's enable input is low at a descriptor boundary.

A descriptor can describe a flat run of bytes or a rectangle. A rectangle is a number of rows, each of a fixed byte count. Between rows a signed 16-bit stride is added to each address. Per-descriptor flags choose whether the source and destination addresses advance after each word. Other flags can replace the source read with zero data or drop the destination write. These let the engine fill a region with zeros, or run a transfer without storing its data. The current source address, destination address and remaining length stay visible on outputs, so a register block can show progress.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the engine is idle. active_o, paused_o, end_o, irq_o and mem_req_o are all low.
- R2: A descriptor is fetched as six 32-bit reads at descriptor address +0, +4, +8, +12, +16 and +20, in that order. The words are flags, source address, destination address, length, stride and link address.
- R3: When flags bit 1 is clear, the whole length word is a byte count handled as a single row. Each beat reads one word from the source address and then writes it to the destination address.
- R4: After each beat the source address advances by 4 if flags bit 8 is set. The destination address advances by 4 if flags bit 4 is set. Otherwise each address stays where it is.
- R5: When flags bit 1 is set, the row count is 1 plus length bits [29:16] and the bytes per row are length bits [15:0]. After every row except the last, the signed stride bits [15:0] are added to the source address and the signed stride bits [31:16] to the destination address.
- R6: When flags bit 11 is set, no source read is issued and zero is written instead. The address increments of R4 still apply.
- R7: When flags bit 7 is set, no destination write is issued. The address increments of R4 still apply.
- R8: len_o holds the fetched length word until the first beat, then updates on each beat. In flat mode it shows the remaining bytes. In 2D mode it shows (remaining rows << 16) | remaining bytes of the current row.
- R9: At the end of each descriptor end_o is set. irq_o is also set if flags bit 0 is set. Both stay set until status_clr_i, and irq_o is never high while end_o is low.
- R10: The engine follows the link word after each descriptor. It stops when the link is zero or chan_en_i is low at that point, or at start if the head address is zero or chan_en_i is low. On stopping, active_o is low and paused_o is high, no request is issued while inactive, and active_o and paused_o are never both high.
- R11: The memory port has at most one request outstanding. A request keeps mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o steady until the cycle mem_ack_i is high, and each acknowledge completes exactly one access.
- R12: A row byte count of zero completes the row with no beats. A zero-length flat descriptor therefore moves no data but still sets end_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a walk when idle |
| head_addr_i | input | AW | Address of the first descriptor |
| chan_en_i | input | 1 | Channel enable, checked at start and between descriptors |
| status_clr_i | input | 1 | Clears end_o and irq_o |
| active_o | output | 1 | Engine is walking descriptors |
| paused_o | output | 1 | Engine has stopped after a walk or a refused start |
| end_o | output | 1 | Sticky descriptor-complete flag |
| irq_o | output | 1 | Sticky interrupt request |
| len_o | output | 32 | Visible remaining-length value |
| src_o | output | AW | Current source address |
| dst_o | output | AW | Current destination address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word accessed |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Access acknowledge |

## Verification
The assertions check the handshake and status rules on every cycle. They watch that a pending request holds its command and data until acknowledged, that no request appears while the engine is inactive, that active and paused are exclusive, and that the sticky end and interrupt flags only fall on a clear and keep the interrupt implied by end. The copy arithmetic can only be shown by the bench's scenarios, which compare the whole memory image and the final address and length outputs with an independent model. That arithmetic covers the 2D row count and signed strides, the effect of the skip flags, the length encoding, descriptor chaining and the early stop when enable drops.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned DESC_WORDS  = 6;
  localparam int unsigned ROW_BYTES_W = 16;
  localparam int unsigned ROW_CNT_W   = 14;
  localparam int unsigned STRIDE_W    = 16;

  localparam int unsigned FLAG_IRQ   = 0;
  localparam int unsigned FLAG_2D    = 1;
  localparam int unsigned FLAG_DINC  = 4;
  localparam int unsigned FLAG_DSKIP = 7;
  localparam int unsigned FLAG_SINC  = 8;
  localparam int unsigned FLAG_SSKIP = 11;

  typedef struct packed {
    logic sskip;
    logic sinc;
    logic dskip;
    logic dinc;
    logic mode2d;
    logic irq_en;
  } flags_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_CHK, ST_RD, ST_WR, ST_ROW, ST_DONE
  } eng_st_e;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic          jump_i,
  input  logic [SW-1:0] stride_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned WORD_BYTES = 4;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] stride_ext;

  assign stride_ext = {{(AW-SW){stride_i[SW-1]}}, stride_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_addr_i;
    else if (step_i)  addr_q <= addr_q + AW'(WORD_BYTES);
    else if (jump_i)  addr_q <= addr_q + stride_ext;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_len_track.sv
module dma_len_track #(
  parameter int unsigned LW = 32,
  parameter int unsigned XW = 16,
  parameter int unsigned RW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          mode2d_i,
  input  logic [LW-1:0] len_word_i,
  input  logic          beat_i,
  input  logic          row_next_i,
  output logic          row_empty_o,
  output logic          last_row_o,
  output logic [LW-1:0] len_view_o
);
  localparam int unsigned YW   = RW + 1;
  localparam int unsigned PADW = LW - XW - YW;

  logic [LW-1:0] xrem_q, xrel_q, view_q, xrem_dec;
  logic [YW-1:0] yrem_q;
  logic          mode_q;

  assign xrem_dec = xrem_q - LW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xrem_q <= '0;
      xrel_q <= '0;
      view_q <= '0;
      yrem_q <= '0;
      mode_q <= 1'b0;
    end else if (load_i) begin
      mode_q <= mode2d_i;
      view_q <= len_word_i;
      if (mode2d_i) begin
        xrem_q <= LW'(len_word_i[XW-1:0]);
        xrel_q <= LW'(len_word_i[XW-1:0]);
        yrem_q <= YW'(len_word_i[XW+RW-1:XW]) + YW'(1);
      end else begin
        xrem_q <= len_word_i;
        xrel_q <= len_word_i;
        yrem_q <= YW'(1);
      end
    end else if (beat_i) begin
      xrem_q <= xrem_dec;
      view_q <= mode_q ? {{PADW{1'b0}}, yrem_q, xrem_dec[XW-1:0]} : xrem_dec;
    end else if (row_next_i) begin
      yrem_q <= yrem_q - YW'(1);
      xrem_q <= xrel_q;
    end
  end

  assign row_empty_o = (xrem_q == '0);
  assign last_row_o  = (yrem_q == YW'(1));
  assign len_view_o  = view_q;
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     head_addr_i,
  input  logic              chan_en_i,
  input  logic              status_clr_i,
  output logic              active_o,
  output logic              paused_o,
  output logic              end_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] len_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int unsigned WIX = $clog2(DESC_WORDS);
  localparam logic [WIX-1:0] WIX_LAST = WIX'(DESC_WORDS - 1);
  localparam int unsigned NSIDE = 2;  // 0: source, 1: destination

  eng_st_e           st_q;
  logic [WIX-1:0]    widx_q;
  logic [AW-1:0]     cur_desc_q;
  flags_t            flags_q;
  logic [DATA_W-1:0] src_w_q, dst_w_q, len_w_q, stride_w_q, link_w_q;
  logic [DATA_W-1:0] data_q;
  logic              active_q, paused_q, end_q, irq_q;

  logic              beat_done, setup, row_next, row_empty, last_row;
  logic [AW-1:0]     side_base   [NSIDE];
  logic              side_step   [NSIDE];
  logic [STRIDE_W-1:0] side_stride [NSIDE];
  logic [AW-1:0]     side_addr   [NSIDE];

  // memory command from state
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = side_addr[0];
    mem_wdata_o = data_q;
    unique case (st_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_desc_q + AW'({widx_q, 2'b00});
      end
      ST_RD: mem_req_o = !flags_q.sskip;
      ST_WR: begin
        mem_req_o  = !flags_q.dskip;
        mem_we_o   = !flags_q.dskip;
        mem_addr_o = side_addr[1];
      end
      default: ;
    endcase
  end

  assign beat_done = (st_q == ST_WR) && (flags_q.dskip || mem_ack_i);
  assign setup     = (st_q == ST_SETUP);
  assign row_next  = (st_q == ST_ROW) && !last_row;

  assign side_base[0]   = AW'(src_w_q);
  assign side_base[1]   = AW'(dst_w_q);
  assign side_step[0]   = beat_done && flags_q.sinc;
  assign side_step[1]   = beat_done && flags_q.dinc;
  assign side_stride[0] = flags_q.mode2d ? stride_w_q[STRIDE_W-1:0] : '0;
  assign side_stride[1] = flags_q.mode2d ? stride_w_q[DATA_W-1:DATA_W-STRIDE_W] : '0;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_unit #(.AW(AW), .SW(STRIDE_W)) u_addr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (setup),
      .load_addr_i (side_base[g]),
      .step_i      (side_step[g]),
      .jump_i      (row_next),
      .stride_i    (side_stride[g]),
      .addr_o      (side_addr[g])
    );
  end

  dma_len_track #(.LW(DATA_W), .XW(ROW_BYTES_W), .RW(ROW_CNT_W)) u_len (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (setup),
    .mode2d_i    (flags_q.mode2d),
    .len_word_i  (len_w_q),
    .beat_i      (beat_done),
    .row_next_i  (row_next),
    .row_empty_o (row_empty),
    .last_row_o  (last_row),
    .len_view_o  (len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      widx_q     <= '0;
      cur_desc_q <= '0;
      flags_q    <= '0;
      src_w_q    <= '0;
      dst_w_q    <= '0;
      len_w_q    <= '0;
      stride_w_q <= '0;
      link_w_q   <= '0;
      data_q     <= '0;
      active_q   <= 1'b0;
      paused_q   <= 1'b0;
      end_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (status_clr_i) begin
        end_q <= 1'b0;
        irq_q <= 1'b0;
      end
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cur_desc_q <= head_addr_i;
          widx_q     <= '0;
          if (chan_en_i && head_addr_i != '0) begin
            st_q     <= ST_FETCH;
            active_q <= 1'b1;
            paused_q <= 1'b0;
          end else begin
            active_q <= 1'b0;
            paused_q <= 1'b1;
          end
        end
        ST_FETCH: if (mem_ack_i) begin
          unique case (widx_q)
            WIX'(0): flags_q <= '{sskip:  mem_rdata_i[FLAG_SSKIP],
                                  sinc:   mem_rdata_i[FLAG_SINC],
                                  dskip:  mem_rdata_i[FLAG_DSKIP],
                                  dinc:   mem_rdata_i[FLAG_DINC],
                                  mode2d: mem_rdata_i[FLAG_2D],
                                  irq_en: mem_rdata_i[FLAG_IRQ]};
            WIX'(1): src_w_q    <= mem_rdata_i;
            WIX'(2): dst_w_q    <= mem_rdata_i;
            WIX'(3): len_w_q    <= mem_rdata_i;
            WIX'(4): stride_w_q <= mem_rdata_i;
            default: link_w_q   <= mem_rdata_i;
          endcase
          if (widx_q == WIX_LAST) begin
            widx_q <= '0;
            st_q   <= ST_SETUP;
          end else begin
            widx_q <= widx_q + WIX'(1);
          end
        end
        ST_SETUP: st_q <= ST_CHK;
        ST_CHK:   st_q <= row_empty ? ST_ROW : ST_RD;
        ST_RD: begin
          if (flags_q.sskip) begin
            data_q <= '0;
            st_q   <= ST_WR;
          end else if (mem_ack_i) begin
            data_q <= mem_rdata_i;
            st_q   <= ST_WR;
          end
        end
        ST_WR:  if (beat_done) st_q <= ST_CHK;
        ST_ROW: st_q <= last_row ? ST_DONE : ST_CHK;
        ST_DONE: begin
          end_q <= 1'b1;
          if (flags_q.irq_en) irq_q <= 1'b1;
          cur_desc_q <= AW'(link_w_q);
          if (chan_en_i && link_w_q != '0) begin
            st_q <= ST_FETCH;
          end else begin
            st_q     <= ST_IDLE;
            active_q <= 1'b0;
            paused_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o = active_q;
  assign paused_o = paused_q;
  assign end_o    = end_q;
  assign irq_o    = irq_q;
  assign src_o    = side_addr[0];
  assign dst_o    = side_addr[1];
endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          status_clr_i,
  input logic          active_o,
  input logic          paused_o,
  input logic          end_o,
  input logic          irq_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i
);
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                   $stable(mem_addr_o) && $stable(mem_wdata_o)));

  p_quiet_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !mem_req_o);

  p_run_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && paused_o));

  p_end_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !status_clr_i) |=> end_o);

  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !status_clr_i) |=> irq_o);

  p_irq_needs_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> end_o);
endmodule

bind dma_chain_engine dma_chain_engine_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .status_clr_i (status_clr_i),
  .active_o     (active_o),
  .paused_o     (paused_o),
  .end_o        (end_o),
  .irq_o        (irq_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ack_i    (mem_ack_i)
);

// File: tb/sim_dma_chain_engine.sv
`timescale 1ns/1ps
module sim_dma_chain_engine;
  localparam int unsigned AW = 32;
  localparam int unsigned NWORDS = 512;
  localparam int unsigned NVEC = 9;
  // flags, source, destination, length, stride
  localparam logic [31:0] VEC [NVEC][5] = '{
    '{32'h110, 32'h200, 32'h400, 32'd16,        32'h0},
    '{32'h112, 32'h200, 32'h400, 32'h0002_0008, 32'h0008_0004},
    '{32'h112, 32'h280, 32'h400, 32'h0001_0008, 32'h0000_FFF0},
    '{32'h910, 32'h200, 32'h400, 32'd12,        32'h0},
    '{32'h190, 32'h200, 32'h400, 32'd8,         32'h0},
    '{32'h010, 32'h208, 32'h400, 32'd12,        32'h0},
    '{32'h110, 32'h200, 32'h400, 32'd0,         32'h0},
    '{32'h111, 32'h200, 32'h400, 32'd4,         32'h0},
    '{32'h112, 32'h200, 32'h400, 32'h0002_0000, 32'h0}
  };
  string vtag [NVEC] = '{"R3", "R5", "R5", "R6", "R7", "R4", "R12", "R9", "R12"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, chan_en = 1'b1, clr = 1'b0;
  logic [AW-1:0] head = '0;
  logic active, paused, end_f, irq;
  logic [31:0] len_v;
  logic [AW-1:0] src_a, dst_a, m_addr;
  logic m_req, m_we, m_ack = 1'b0;
  logic [31:0] m_wdata, m_rdata = '0;

  logic [31:0] mem [NWORDS];
  logic [31:0] exp_mem [NWORDS];
  logic [31:0] rd_log [8];
  int rd_cnt, wr_cnt, exp_reads, exp_writes;
  logic [31:0] exp_src, exp_dst, exp_len;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dma_chain_engine #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .head_addr_i(head),
    .chan_en_i(chan_en), .status_clr_i(clr), .active_o(active),
    .paused_o(paused), .end_o(end_f), .irq_o(irq), .len_o(len_v),
    .src_o(src_a), .dst_o(dst_a), .mem_req_o(m_req), .mem_we_o(m_we),
    .mem_addr_o(m_addr), .mem_wdata_o(m_wdata), .mem_rdata_i(m_rdata),
    .mem_ack_i(m_ack)
  );

  // memory responder: ack one negedge after a request, drop at the next
  initial begin
    forever begin
      @(negedge clk);
      if (m_ack) m_ack = 1'b0;
      else if (rst_n && m_req) begin
        m_ack = 1'b1;
        if (m_we) begin
          mem[m_addr[10:2]] = m_wdata;
          wr_cnt++;
        end else begin
          m_rdata = mem[m_addr[10:2]];
          if (rd_cnt < 8) rd_log[rd_cnt] = m_addr;
          rd_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=running expected=idle");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < NWORDS; i++) begin
      if (i >= 128 && i < 256)      mem[i] = 32'hA500_0000 | 32'(i);
      else if (i >= 256 && i < 384) mem[i] = 32'hDEAD_0000 | 32'(i);
      else                          mem[i] = '0;
    end
    rd_cnt = 0; wr_cnt = 0; exp_reads = 0; exp_writes = 0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] f, s, d, l, st, nx);
    mem[at[10:2]]     = f;
    mem[at[10:2] + 1] = s;
    mem[at[10:2] + 2] = d;
    mem[at[10:2] + 3] = l;
    mem[at[10:2] + 4] = st;
    mem[at[10:2] + 5] = nx;
  endtask

  task automatic snap();
    for (int i = 0; i < NWORDS; i++) exp_mem[i] = mem[i];
  endtask

  // independent model of one descriptor, from the requirements
  task automatic model(input logic [31:0] f, s_in, d_in, l, st);
    logic [31:0] s, d, x, xl, rows, ss, ds, data;
    s = s_in; d = d_in; exp_len = l;
    rows = f[1] ? 32'(l[29:16]) + 1 : 1;
    xl   = f[1] ? 32'(l[15:0]) : l;
    ss   = f[1] ? {{16{st[15]}}, st[15:0]} : '0;
    ds   = f[1] ? {{16{st[31]}}, st[31:16]} : '0;
    exp_reads += 6;
    for (logic [31:0] r = rows; r != 0; r--) begin
      x = xl;
      while (x != 0) begin
        if (f[11]) data = '0;
        else begin data = exp_mem[s[10:2]]; exp_reads++; end
        if (f[8]) s += 4;
        if (!f[7]) begin exp_mem[d[10:2]] = data; exp_writes++; end
        if (f[4]) d += 4;
        x -= 4;
        exp_len = f[1] ? ((r << 16) | {16'h0, x[15:0]}) : x;
      end
      if (r != 1) begin s += ss; d += ds; end
    end
    exp_src = s; exp_dst = d;
  endtask

  task automatic go(input logic [31:0] h);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1; head = h;
    @(negedge clk); start = 1'b0;
    while (!(paused && !active)) @(negedge clk);
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < NWORDS; i++) if (mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "active", 32'(active), 0);
    check("R1", "paused", 32'(paused), 0);
    check("R1", "end", 32'(end_f), 0);
    check("R1", "irq", 32'(irq), 0);
    check("R1", "req", 32'(m_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      init_mem();
      put_desc(32'h40, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 32'h0);
      snap();
      model(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      go(32'h40);
      check(vtag[v], $sformatf("vec%0d memory mismatches", v), 32'(mem_diff()), 0);
      check("R4", $sformatf("vec%0d src", v), src_a, exp_src);
      check("R4", $sformatf("vec%0d dst", v), dst_a, exp_dst);
      check("R8", $sformatf("vec%0d len view", v), len_v, exp_len);
      check("R9", $sformatf("vec%0d end", v), 32'(end_f), 1);
      check("R9", $sformatf("vec%0d irq", v), 32'(irq), 32'(VEC[v][0][0]));
      check("R11", $sformatf("vec%0d reads", v), 32'(rd_cnt), 32'(exp_reads));
      check("R7", $sformatf("vec%0d writes", v), 32'(wr_cnt), 32'(exp_writes));
      check("R6", $sformatf("vec%0d data reads", v), 32'(rd_cnt - 6), 32'(exp_reads - 6));
      check("R10", $sformatf("vec%0d stopped", v), {30'h0, active, paused}, 32'h1);
      if (v == 0)
        for (int k = 0; k < 6; k++)
          check("R2", $sformatf("fetch %0d addr", k), rd_log[k], 32'h40 + 32'(4 * k));
    end

    // two-descriptor chain, interrupt from the second only
    init_mem();
    put_desc(32'h40, 32'h110, 32'h200, 32'h400, 32'd8, 32'h0, 32'h60);
    put_desc(32'h60, 32'h111, 32'h220, 32'h420, 32'd8, 32'h0, 32'h0);
    snap();
    model(32'h110, 32'h200, 32'h400, 32'd8, 32'h0);
    model(32'h111, 32'h220, 32'h420, 32'd8, 32'h0);
    go(32'h40);
    check("R10", "chain memory mismatches", 32'(mem_diff()), 0);
    check("R10", "chain reads", 32'(rd_cnt), 32'(exp_reads));
    check("R10", "chain final dst", dst_a, exp_dst);
    check("R9", "chain irq", 32'(irq), 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R9", "end after clear", 32'(end_f), 0);
    check("R9", "irq after clear", 32'(irq), 0);

    // enable dropped during first descriptor: second never runs
    init_mem();
    put_desc(32'h40, 32'h110, 32'h200, 32'h400, 32'd8, 32'h0, 32'h60);
    put_desc(32'h60, 32'h111, 32'h220, 32'h420, 32'd8, 32'h0, 32'h0);
    snap();
    model(32'h110, 32'h200, 32'h400, 32'd8, 32'h0);
    @(negedge clk); start = 1'b1; head = 32'h40;
    @(negedge clk); start = 1'b0; chan_en = 1'b0;
    while (!(paused && !active)) @(negedge clk);
    check("R10", "disabled chain memory mismatches", 32'(mem_diff()), 0);
    check("R10", "disabled chain reads", 32'(rd_cnt), 32'(exp_reads));
    check("R10", "disabled chain irq", 32'(irq), 0);
    check("R10", "disabled chain end", 32'(end_f), 1);

    // start refused with enable low, then with a zero head
    init_mem();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1; head = 32'h40;
    @(negedge clk); start = 1'b0; chan_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "enable-low start reads", 32'(rd_cnt), 0);
    check("R10", "enable-low start state", {30'h0, active, paused}, 32'h1);
    go(32'h0);
    repeat (4) @(negedge clk);
    check("R10", "zero-head reads", 32'(rd_cnt), 0);
    check("R10", "zero-head state", {30'h0, active, paused}, 32'h1);
    check("R9", "zero-head end", 32'(end_f), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule